// File: doc/BRIEF.md
# Internal Oscillator Clock Switch Controller

This block chooses the system clock of a small microcontroller and moves it between sources without glitches. A software select bit picks either the primary source named by a 3-bit configuration field or the internal oscillator. When the internal path is chosen, a 3-bit frequency code selects one of two things. Code 000 selects the low-frequency oscillator. Any other code selects a tap of a postscaler that divides the high-frequency oscillator.

A request may name an oscillator that is switched off. In that case the block enables the oscillator and waits a parameterized start-up time, counted on the always-running reference clock. It then hands the output over on the next falling edge of the clock currently being driven. Moving between postscaler taps of an oscillator that is already running needs no start-up wait.

An automatic-switch input stands in for the fail-safe monitor and two-speed start-up. It forces the internal path but leaves the software bit untouched. Status outputs report which internal oscillators are stable, and whether the clock runs from a primary source that is fully started.

All oscillator clocks enter as level inputs and are sampled on the reference clock. The output clock is a registered copy of the selected source.

Top module: `clksw_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, the software select bit is 0, the frequency code equals FSEL_RST (default 110), and all of the following are 0: the output clock, both enables, both stable flags and the start-up status.
- R2: With the effective select at 0 (software bit 0 and automatic request 0), the output clock reproduces the primary clock input two reference cycles late.
- R3: With the effective select at 1, code 000 routes the low-frequency oscillator. Code c from 001 to 111 routes the high-frequency oscillator divided by 2^(7-c): 111 is undivided and 001 is divide-by-64. The divider counts rising edges of the high-frequency input.
- R4: An oscillator that is needed by the target or the active source has its enable driven high. Its stable flag rises exactly STARTUP_CYC cycles after the write that first required it, where STARTUP_CYC = REF_KHZ*STARTUP_US/1000. The output never moves to an oscillator whose stable flag is low.
- R5: A source change takes effect only on the cycle after the active source's sampled level falls. The output clock is therefore low when the new source takes over, and no shortened high pulse of the old source appears.
- R6: A change between two high-frequency taps while that oscillator is stable does not drop its stable flag. The change completes on the next falling edge without any start-up wait.
- R7: The software select bit and frequency code change only on a write strobe. The automatic request changes the routed source but never changes the software select bit.
- R8: The start-up status is 1 only when the primary source is active. If the configuration field is below 3 (the three crystal modes), it also requires the start-up timer done input.
- R9: A stable flag is never high while its enable is low. An oscillator that neither the active source nor the target uses is disabled, and its stable flag cleared, on the next cycle.
- R10: A new request made while a switch is pending replaces the old one. The switch then proceeds toward the newest selection only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the select bit and frequency code |
| wr_scs | input | 1 | Software select value to write |
| wr_fsel | input | FSEL_W | Frequency code to write |
| cfg_mode | input | CFG_W | Configured primary source mode |
| ost_done | input | 1 | Primary start-up timer has expired |
| auto_int | input | 1 | Automatic switch request to the internal path |
| pri_clk | input | 1 | Primary clock level |
| lf_clk | input | 1 | Low-frequency oscillator level |
| hf_clk | input | 1 | High-frequency oscillator level |
| sys_clk_o | output | 1 | Switched system clock |
| lf_en_o | output | 1 | Low-frequency oscillator enable |
| hf_en_o | output | 1 | High-frequency oscillator enable |
| lf_stable_o | output | 1 | Low-frequency oscillator stable |
| hf_stable_o | output | 1 | High-frequency oscillator stable |
| osts_o | output | 1 | Running from a fully started primary source |
| scs_o | output | 1 | Software select bit |
| fsel_o | output | FSEL_W | Frequency code |

## Verification
The bench builds the block with REF_KHZ = 2000, so the start-up wait is 20 reference cycles instead of 320. This lets every kind of switch complete several times within the run: from primary to internal, between taps, to low frequency, a cancelled low-frequency request, and back to primary. The high-frequency input toggles every cycle, so the slowest tap (divide-by-64) has a 128-cycle period and stays short enough to observe falling-edge handover on every source.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  typedef enum logic [1:0] {SRC_PRI, SRC_LF, SRC_HF} src_kind_e;

  // A routed source: kind plus postscaler code (zero unless kind is SRC_HF)
  typedef struct packed {
    src_kind_e  kind;
    logic [2:0] tap;
  } src_t;
endpackage

// File: rtl/clksw_postscaler.sv
module clksw_postscaler #(
  parameter int CODE_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hf_clk,
  output logic [2**CODE_W-1:0] tap_lvl
);
  localparam int MAXC  = 2**CODE_W - 1;
  localparam int DIV_W = MAXC - 1;

  logic             hf_q;
  logic [DIV_W-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hf_q    <= 1'b0;
      div_cnt <= '0;
    end else begin
      hf_q <= hf_clk;
      if (hf_clk && !hf_q) div_cnt <= div_cnt + 1'b1;
    end
  end

  // code MAXC is undivided; lower codes take higher divider bits
  for (genvar c = 0; c <= MAXC; c++) begin : g_tap
    if (c == 0) begin : g_none
      assign tap_lvl[c] = 1'b0;
    end else if (c == MAXC) begin : g_full
      assign tap_lvl[c] = hf_q;
    end else begin : g_div
      assign tap_lvl[c] = div_cnt[MAXC-1-c];
    end
  end
endmodule

// File: rtl/clksw_osc_start.sv
module clksw_osc_start #(
  parameter int STARTUP_CYC = 320
) (
  input  logic clk,
  input  logic rst,
  input  logic want,
  output logic en,
  output logic rdy
);
  localparam int CW = $clog2(STARTUP_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= 1'b0;
      rdy <= 1'b0;
      cnt <= '0;
    end else begin
      en <= want;
      if (!want) begin
        rdy <= 1'b0;
        cnt <= '0;
      end else if (!rdy) begin
        if (cnt == CW'(STARTUP_CYC - 1)) rdy <= 1'b1;
        else                             cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int REF_KHZ    = 32000,
  parameter int STARTUP_US = 10,
  parameter int FSEL_W     = 3,
  parameter int CFG_W      = 3,
  parameter int FSEL_RST   = 6,
  parameter int OST_MODES  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_scs,
  input  logic [FSEL_W-1:0] wr_fsel,
  input  logic [CFG_W-1:0]  cfg_mode,
  input  logic              ost_done,
  input  logic              auto_int,
  input  logic              pri_clk,
  input  logic              lf_clk,
  input  logic              hf_clk,
  output logic              sys_clk_o,
  output logic              lf_en_o,
  output logic              hf_en_o,
  output logic              lf_stable_o,
  output logic              hf_stable_o,
  output logic              osts_o,
  output logic              scs_o,
  output logic [FSEL_W-1:0] fsel_o
);
  localparam int STARTUP_CYC = REF_KHZ * STARTUP_US / 1000;
  localparam int NCODE       = 2**FSEL_W;

  logic              scs_q;
  logic [FSEL_W-1:0] fsel_q;
  logic              pri_q, lf_q;
  logic [NCODE-1:0]  hf_tap;
  src_t              act, act_n, tgt;
  logic              cur_lvl, lvl_prev, fall, tgt_rdy, do_sw;
  logic [1:0]        want, en, rdy;

  // software-visible select state; only a write changes it
  always_ff @(posedge clk) begin
    if (rst) begin
      scs_q  <= 1'b0;
      fsel_q <= FSEL_W'(FSEL_RST);
    end else if (wr_en) begin
      scs_q  <= wr_scs;
      fsel_q <= wr_fsel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pri_q <= 1'b0;
      lf_q  <= 1'b0;
    end else begin
      pri_q <= pri_clk;
      lf_q  <= lf_clk;
    end
  end

  clksw_postscaler #(.CODE_W(FSEL_W)) u_post (
    .clk     (clk),
    .rst     (rst),
    .hf_clk  (hf_clk),
    .tap_lvl (hf_tap)
  );

  function automatic src_t pick(input logic internal, input logic [FSEL_W-1:0] code);
    src_t s;
    s.tap = '0;
    if (!internal)        s.kind = SRC_PRI;
    else if (code == '0)  s.kind = SRC_LF;
    else begin
      s.kind = SRC_HF;
      s.tap  = 3'(code);
    end
    return s;
  endfunction

  always_comb begin
    tgt = pick(scs_q | auto_int, fsel_q);
    unique case (act.kind)
      SRC_LF:  cur_lvl = lf_q;
      SRC_HF:  cur_lvl = hf_tap[act.tap[FSEL_W-1:0]];
      default: cur_lvl = pri_q;
    endcase
    unique case (tgt.kind)
      SRC_LF:  tgt_rdy = rdy[0];
      SRC_HF:  tgt_rdy = rdy[1];
      default: tgt_rdy = 1'b1;
    endcase
    fall    = lvl_prev && !cur_lvl;
    do_sw   = (tgt != act) && tgt_rdy && fall;
    act_n   = do_sw ? tgt : act;
    want[0] = (act.kind == SRC_LF) || (tgt.kind == SRC_LF);
    want[1] = (act.kind == SRC_HF) || (tgt.kind == SRC_HF);
  end

  // index 0: low-frequency oscillator, index 1: high-frequency oscillator
  for (genvar i = 0; i < 2; i++) begin : g_osc
    clksw_osc_start #(.STARTUP_CYC(STARTUP_CYC)) u_start (
      .clk  (clk),
      .rst  (rst),
      .want (want[i]),
      .en   (en[i]),
      .rdy  (rdy[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act       <= '{kind: SRC_PRI, tap: '0};
      lvl_prev  <= 1'b0;
      sys_clk_o <= 1'b0;
      osts_o    <= 1'b0;
    end else begin
      act       <= act_n;
      lvl_prev  <= cur_lvl;
      sys_clk_o <= cur_lvl;
      osts_o    <= (act_n.kind == SRC_PRI) &&
                   ((cfg_mode >= CFG_W'(OST_MODES)) || ost_done);
    end
  end

  assign lf_en_o     = en[0];
  assign hf_en_o     = en[1];
  assign lf_stable_o = rdy[0];
  assign hf_stable_o = rdy[1];
  assign scs_o       = scs_q;
  assign fsel_o      = fsel_q;
endmodule

// File: rtl/clksw_ctrl_chk.sv
module clksw_ctrl_chk
  import clksw_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic wr_en,
  input src_t act,
  input src_t tgt,
  input logic sys_clk_o,
  input logic lf_en_o,
  input logic hf_en_o,
  input logic lf_stable_o,
  input logic hf_stable_o,
  input logic osts_o,
  input logic scs_o
);
  a_r5_handover_low: assert property (@(posedge clk) disable iff (rst)
    (act != $past(act)) |-> !sys_clk_o);

  a_r4_lf_ready_first: assert property (@(posedge clk) disable iff (rst)
    (act.kind == SRC_LF && $past(act.kind) != SRC_LF) |-> $past(lf_stable_o));

  a_r4_hf_ready_first: assert property (@(posedge clk) disable iff (rst)
    (act.kind == SRC_HF && $past(act.kind) != SRC_HF) |-> $past(hf_stable_o));

  a_r6_tap_keeps_stable: assert property (@(posedge clk) disable iff (rst)
    (act.kind == SRC_HF && tgt.kind == SRC_HF) |=> hf_stable_o);

  a_r7_select_held: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(scs_o));

  a_r8_status_primary: assert property (@(posedge clk) disable iff (rst)
    osts_o |-> act.kind == SRC_PRI);

  a_r9_lf_stable_en: assert property (@(posedge clk) disable iff (rst)
    lf_stable_o |-> lf_en_o);

  a_r9_hf_stable_en: assert property (@(posedge clk) disable iff (rst)
    hf_stable_o |-> hf_en_o);
endmodule

bind clksw_ctrl clksw_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .act         (act),
  .tgt         (tgt),
  .sys_clk_o   (sys_clk_o),
  .lf_en_o     (lf_en_o),
  .hf_en_o     (hf_en_o),
  .lf_stable_o (lf_stable_o),
  .hf_stable_o (hf_stable_o),
  .osts_o      (osts_o),
  .scs_o       (scs_o)
);

// File: tb/clksw_ctrl_test.sv
module clksw_ctrl_test;
  localparam int REF_KHZ = 2000;
  localparam int ST      = REF_KHZ * 10 / 1000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, wr_scs = 1'b0;
  logic [2:0] wr_fsel = 3'd0;
  logic [2:0] cfg_mode = 3'd2;
  logic       ost_done = 1'b0, auto_int = 1'b0;
  logic       pri_clk = 1'b0, lf_clk = 1'b0, hf_clk = 1'b0;
  logic       sys_clk_o, lf_en_o, hf_en_o, lf_stable_o, hf_stable_o, osts_o, scs_o;
  logic [2:0] fsel_o;

  int compared = 0, mismatched = 0, cyc = 0;

  always #2.5 clk = ~clk;

  clksw_ctrl #(.REF_KHZ(REF_KHZ)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_scs(wr_scs), .wr_fsel(wr_fsel),
    .cfg_mode(cfg_mode), .ost_done(ost_done), .auto_int(auto_int),
    .pri_clk(pri_clk), .lf_clk(lf_clk), .hf_clk(hf_clk),
    .sys_clk_o(sys_clk_o), .lf_en_o(lf_en_o), .hf_en_o(hf_en_o),
    .lf_stable_o(lf_stable_o), .hf_stable_o(hf_stable_o), .osts_o(osts_o),
    .scs_o(scs_o), .fsel_o(fsel_o)
  );

  // source waveforms: primary period 6, low-frequency 14, high-frequency 2
  always @(negedge clk) begin
    cyc     <= cyc + 1;
    pri_clk <= ((cyc + 1) % 6) < 3;
    lf_clk  <= ((cyc + 1) % 14) < 7;
    hf_clk  <= ((cyc + 1) % 2) == 1;
  end

  // behavioural model: source -1 primary, 0 low-frequency, 1..7 postscaler code
  int m_act, m_rises, m_cnt_lf, m_cnt_hf;
  bit m_prev, m_sys, m_en_lf, m_en_hf, m_rdy_lf, m_rdy_hf, m_osts, m_scs;
  bit m_priq, m_lfq, m_hfq;
  int m_fsel;

  function automatic bit lvl_of(int s);
    if (s < 0)  return m_priq;
    if (s == 0) return m_lfq;
    if (s == 7) return m_hfq;
    return bit'((m_rises >> (6 - s)) & 1);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_act = -1; m_rises = 0; m_cnt_lf = 0; m_cnt_hf = 0;
      m_prev = 0; m_sys = 0; m_en_lf = 0; m_en_hf = 0; m_rdy_lf = 0; m_rdy_hf = 0;
      m_osts = 0; m_scs = 0; m_fsel = 6; m_priq = 0; m_lfq = 0; m_hfq = 0;
    end else begin
      int  tgt, nact;
      bit  cur, ready, want_lf, want_hf;
      tgt   = !(m_scs || auto_int) ? -1 : m_fsel;
      cur   = lvl_of(m_act);
      ready = (tgt < 0) ? 1'b1 : (tgt == 0) ? m_rdy_lf : m_rdy_hf;
      nact  = (tgt != m_act && ready && m_prev && !cur) ? tgt : m_act;
      want_lf = (m_act == 0) || (tgt == 0);
      want_hf = (m_act > 0) || (tgt > 0);
      m_en_lf = want_lf; m_en_hf = want_hf;
      if (!want_lf) begin m_rdy_lf = 0; m_cnt_lf = 0; end
      else if (!m_rdy_lf) begin if (m_cnt_lf == ST - 1) m_rdy_lf = 1; else m_cnt_lf++; end
      if (!want_hf) begin m_rdy_hf = 0; m_cnt_hf = 0; end
      else if (!m_rdy_hf) begin if (m_cnt_hf == ST - 1) m_rdy_hf = 1; else m_cnt_hf++; end
      m_osts = (nact < 0) && (cfg_mode >= 3 || ost_done);
      m_sys = cur; m_prev = cur; m_act = nact;
      if (hf_clk && !m_hfq) m_rises++;
      m_priq = pri_clk; m_lfq = lf_clk; m_hfq = hf_clk;
      if (wr_en) begin m_scs = wr_scs; m_fsel = int'(wr_fsel); end
    end
  end

  task automatic check(string req, int actual, int expected);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, actual, expected);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check("R2 R3 R5 R10 sys_clk", int'(sys_clk_o), int'(m_sys));
      check("R4 R9 lf_en", int'(lf_en_o), int'(m_en_lf));
      check("R4 R9 hf_en", int'(hf_en_o), int'(m_en_hf));
      check("R4 R9 lf_stable", int'(lf_stable_o), int'(m_rdy_lf));
      check("R4 R6 hf_stable", int'(hf_stable_o), int'(m_rdy_hf));
      check("R8 osts", int'(osts_o), int'(m_osts));
      check("R7 scs", int'(scs_o), int'(m_scs));
      check("R7 fsel", int'(fsel_o), m_fsel);
    end
  end

  bit watch_hf = 0, hf_dropped = 0;
  always @(negedge clk) if (watch_hf && !hf_stable_o) hf_dropped = 1;

  task automatic write_sel(bit s, logic [2:0] f);
    @(negedge clk); wr_en = 1; wr_scs = s; wr_fsel = f;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired at cycle %0d: actual 1 expected 0", cyc);
    finish_run();
  end

  initial begin
    int k;
    idle(3);
    // R1 reset state
    check("R1 sys_clk", int'(sys_clk_o), 0);
    check("R1 enables", int'({lf_en_o, hf_en_o}), 0);
    check("R1 stables", int'({lf_stable_o, hf_stable_o}), 0);
    check("R1 osts", int'(osts_o), 0);
    check("R1 scs", int'(scs_o), 0);
    check("R1 fsel", int'(fsel_o), 6);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check("R1 first cycle enables", int'({lf_en_o, hf_en_o}), 0);

    // R2 and R8: primary crystal mode, timer not done, then done
    idle(40);
    check("R8 osts waits for timer", int'(osts_o), 0);
    ost_done = 1; idle(3);
    check("R8 osts after timer", int'(osts_o), 1);

    // R4: start the high-frequency oscillator
    write_sel(1, 3'd6);
    k = 0;
    while (!hf_stable_o && k < 1000) begin @(negedge clk); k++; end
    check("R4 hf start-up cycles", k, ST);
    idle(60);
    check("R8 osts on internal", int'(osts_o), 0);

    // R6: tap to tap without start-up wait
    watch_hf = 1;
    write_sel(1, 3'd7); idle(30);
    write_sel(1, 3'd1); idle(300);
    write_sel(1, 3'd4); idle(80);
    watch_hf = 0;
    check("R6 hf stable held across taps", int'(hf_dropped), 0);

    // R10: low-frequency request cancelled while pending
    write_sel(1, 3'd0); idle(5);
    check("R4 lf enabled for pending switch", int'(lf_en_o), 1);
    write_sel(1, 3'd3); idle(4);
    check("R10 lf released after cancel", int'(lf_en_o), 0);
    check("R10 lf stable cleared", int'(lf_stable_o), 0);
    idle(80);

    // R4 and R3: low-frequency start-up and routing
    write_sel(1, 3'd0);
    k = 0;
    while (!lf_stable_o && k < 1000) begin @(negedge clk); k++; end
    check("R4 lf start-up cycles", k, ST);
    idle(80);
    check("R9 hf released once on low-frequency", int'(hf_en_o), 0);

    // R2: back to primary in LP mode without timer
    cfg_mode = 3'd0; ost_done = 0;
    write_sel(0, 3'd0); idle(60);
    check("R8 osts LP without timer", int'(osts_o), 0);
    check("R9 lf released on primary", int'(lf_en_o), 0);
    ost_done = 1; idle(3);
    check("R8 osts LP with timer", int'(osts_o), 1);

    // R7: automatic switch keeps software bit
    auto_int = 1; idle(100);
    check("R7 scs unchanged by auto switch", int'(scs_o), 0);
    check("R8 osts off under auto switch", int'(osts_o), 0);
    auto_int = 0; idle(60);

    // R7: code write while on primary only changes fields
    cfg_mode = 3'd5;
    write_sel(0, 3'd7); idle(40);
    check("R7 fsel written", int'(fsel_o), 7);
    check("R2 no internal enable", int'({lf_en_o, hf_en_o}), 0);
    finish_run();
  end
endmodule